// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Controller

This block is the bus-facing slave of a 128-byte, byte-wide nonvolatile store. It samples a two-wire serial bus (clock plus open-drain data) with the system clock. It recognises START and STOP conditions and accepts a device-select byte whose high nibble is 1010. It then serves byte writes, page writes of up to eight bytes, current-address reads, random reads and sequential reads. Acknowledge bits and read data leave the block as a pull-low request. The pad ties this request to the shared data line.

Written bytes first collect in an eight-byte page buffer. They reach the array only when a STOP arrives while the write-enable level is high. That STOP also starts a programming interval of fixed length, counted in system clocks. For the whole interval the block stays silent on the bus. The control pins are plain level signals. No valid/ready interface exists, because bytes move only over the two-wire bus, and the bus master paces every transfer.

Top module: `tws_eeprom_slave`

## Requirements
- R1: After reset, every array byte reads back as 0x00 and `sda_pull_low` is 0.
- R2: START is data falling while clock is high, and STOP is data rising while clock is high. The first byte after START is sent MSB first. It is accepted only when bits 7:4 equal 1010. Bits 3:1 are ignored, and bit 0 = 1 selects read, 0 selects write. A non-matching select byte gets no acknowledge, and the block leaves the data line released until the next START.
- R3: Every byte the block accepts is acknowledged by pulling data low during the ninth clock: the select byte, the word address and each write data byte. The pull-low request changes only while the clock is low.
- R4: A write sequence (select with bit 0 = 0, word address, data) followed by STOP with `wr_enable` = 1 stores the data at that address.
- R5: If `wr_enable` = 0 when the STOP arrives, the array keeps its contents and no programming interval starts. A START right after that STOP is acknowledged.
- R6: A page write keeps the upper four address bits fixed and advances only the lower three. When more than eight bytes are sent, later bytes wrap within the same aligned eight-byte page and overwrite earlier ones. Bytes outside the page are untouched.
- R7: A committing STOP starts a busy interval of PROG_CYCLES clocks. During it the block ignores START and does not pull data low, so a select byte gets no acknowledge. After the interval, select bytes are acknowledged again.
- R8: A random read returns the byte at the given address. It is a write select plus word address, then a repeated START and a read select. It does not change the array.
- R9: In a sequential read, each master acknowledge (data low on the ninth clock) moves to the next address. The address wraps from 0x7F to 0x00.
- R10: A current-address read (START, read select) returns the byte one past the last byte read.
- R11: After the master withholds acknowledge on a read byte, the block releases data and stays released for any further clocks until STOP or START.
- R12: Bit 7 of the word address byte is ignored, so address 0x85 reaches location 0x05.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Resolved bus data line as seen at the pad |
| wr_enable | input | 1 | Write-enable level, sampled at the committing STOP |
| sda_pull_low | output | 1 | 1 requests the pad to pull the data line low |

## Verification
The bench sends more than eight bytes into one page. A design that carried the address into the next page would corrupt the neighbouring page and lose the wrapped bytes. It reads across 0x7F to 0x00 and then performs a current-address read, so a pointer that fails to advance on the last, unacknowledged byte returns the wrong data. It starts a new transfer right after a committing STOP and again after a STOP with write-enable low. A design that answered while busy, or that started a programming interval without a write, would acknowledge in the wrong case. It also keeps clocking after a master NACK and sends a select byte with the wrong high nibble, to catch any stray pull-low.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEV,
    S_DEV_ACK,
    S_ADDR,
    S_ADDR_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_RDATA,
    S_RACK,
    S_WAIT
  } tws_state_e;
endpackage

// File: rtl/tws_line_monitor.sv
module tws_line_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_q;
  logic [SYNC_STAGES-1:0] sda_q;
  logic                   scl_p;
  logic                   sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_in;
          sda_q <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
          sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_s = scl_q[SYNC_STAGES-1];
  assign sda_s = sda_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = !scl_p && scl_s;
  assign scl_fall = scl_p && !scl_s;
  assign start_ev = scl_p && scl_s && sda_p && !sda_s;
  assign stop_ev  = scl_p && scl_s && !sda_p && sda_s;
endmodule

// File: rtl/tws_prog_timer.sv
module tws_prog_timer #(
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (launch) begin
      remain <= CW'(PROG_CYCLES);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

  // R7: a new programming interval is never launched on top of a running one
  p_launch_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
endmodule

// File: rtl/tws_page_store.sv
module tws_page_store
  import tws_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 3,
  localparam int ROW_W = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              buf_we,
  input  logic [PAGE_W-1:0] buf_col,
  input  logic [BYTE_W-1:0] buf_data,
  input  logic              buf_clear,
  input  logic              commit,
  input  logic [ROW_W-1:0]  commit_row,
  output logic              any_pending
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [BYTE_W-1:0]     mem  [DEPTH];
  logic [BYTE_W-1:0]     pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int c = 0; c < PAGE_BYTES; c++) pbuf[c] <= '0;
      pvalid <= '0;
    end else begin
      if (commit) begin
        for (int c = 0; c < PAGE_BYTES; c++) begin
          if (pvalid[c]) mem[{commit_row, PAGE_W'(c)}] <= pbuf[c];
        end
      end
      if (buf_clear) begin
        pvalid <= '0;
      end else if (buf_we) begin
        pbuf[buf_col]   <= buf_data;
        pvalid[buf_col] <= 1'b1;
      end
    end
  end

  assign rd_data     = mem[rd_addr];
  assign any_pending = |pvalid;

  // R6: a buffer fill and a buffer clear never arrive in the same cycle
  p_ops_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_we, buf_clear}));
endmodule

// File: rtl/tws_eeprom_slave.sv
module tws_eeprom_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wr_enable,
  output logic sda_pull_low
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy;

  tws_state_e        state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic [ADDR_W-1:0] addr_ptr;
  logic              drive;
  logic              rw_read;
  logic              master_ack;

  logic [BYTE_W-1:0] rd_data;
  logic              any_pending;
  logic              buf_we, buf_clear, commit;
  logic              bus_start, bus_stop, byte_done;

  tws_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  assign bus_start = start_ev && !busy;
  assign bus_stop  = stop_ev && !busy;
  assign byte_done = scl_fall && (bitcnt == 4'd8);

  assign buf_we    = (state == S_WDATA) && byte_done;
  assign buf_clear = bus_start || bus_stop;
  assign commit    = bus_stop && wr_enable && any_pending;

  tws_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_addr     (addr_ptr),
    .rd_data     (rd_data),
    .buf_we      (buf_we),
    .buf_col     (addr_ptr[PAGE_W-1:0]),
    .buf_data    (shreg),
    .buf_clear   (buf_clear),
    .commit      (commit),
    .commit_row  (addr_ptr[ADDR_W-1:PAGE_W]),
    .any_pending (any_pending)
  );

  tws_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (commit),
    .busy   (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txreg      <= '0;
      addr_ptr   <= '0;
      drive      <= 1'b0;
      rw_read    <= 1'b0;
      master_ack <= 1'b0;
    end else if (bus_stop) begin
      state <= S_IDLE;
      drive <= 1'b0;
    end else if (bus_start) begin
      state  <= S_DEV;
      bitcnt <= '0;
      drive  <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= '0;
            if (state == S_DEV) begin
              if (shreg[7:4] == DEV_CODE) begin
                drive   <= 1'b1;
                rw_read <= shreg[0];
                state   <= S_DEV_ACK;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_ADDR) begin
              drive    <= 1'b1;
              addr_ptr <= shreg[ADDR_W-1:0];
              state    <= S_ADDR_ACK;
            end else begin
              drive                  <= 1'b1;
              addr_ptr[PAGE_W-1:0]   <= addr_ptr[PAGE_W-1:0] + 1'b1;
              state                  <= S_WDATA_ACK;
            end
          end
        end
        S_DEV_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw_read) begin
              txreg <= rd_data;
              drive <= !rd_data[BYTE_W-1];
              state <= S_RDATA;
            end else begin
              drive <= 1'b0;
              state <= S_ADDR;
            end
          end
        end
        S_ADDR_ACK, S_WDATA_ACK: begin
          if (scl_fall) begin
            drive <= 1'b0;
            state <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              drive    <= 1'b0;
              addr_ptr <= addr_ptr + 1'b1;
              bitcnt   <= '0;
              state    <= S_RACK;
            end else begin
              txreg  <= {txreg[BYTE_W-2:0], 1'b0};
              drive  <= !txreg[BYTE_W-2];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            master_ack <= !sda_s;
          end else if (scl_fall) begin
            if (master_ack) begin
              txreg <= rd_data;
              drive <= !rd_data[BYTE_W-1];
              state <= S_RDATA;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_low = drive;

  // R2: no pull-low while waiting for a START
  p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_pull_low);

  // R3: the data request only moves while the bus clock is low
  p_change_clock_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_low) |-> !scl_s);

  // R5: a programming interval begins only if write enable was high
  p_commit_needs_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_enable));

  // R7: silent on the bus during programming
  p_busy_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_low);

  // R11: released after a master NACK
  p_nack_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> !sda_pull_low);
endmodule

// File: tb/tws_eeprom_slave_test.sv
module tws_eeprom_slave_test;
  localparam int PROG = 1500;
  localparam int Q    = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic we    = 1'b1;
  logic sda_pull_low;
  logic sda_line;

  assign sda_line = m_sda & ~sda_pull_low;

  tws_eeprom_slave #(.PROG_CYCLES(PROG)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (m_scl),
    .sda_in       (sda_line),
    .wr_enable    (we),
    .sda_pull_low (sda_pull_low)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    m_sda = 1'b0; wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(1);
    m_scl = 1'b1; wq(1);
    m_sda = 1'b1; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(1);
      m_scl = 1'b1; wq(2);
      m_scl = 1'b0; wq(1);
    end
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    acked = !sda_line;
    wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1);
      m_scl = 1'b1; wq(1);
      d[i] = sda_line;
      wq(1);
      m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wq(1);
    m_scl = 1'b1; wq(2);
    m_scl = 1'b0; wq(1);
    m_sda = 1'b1;
  endtask

  task automatic write_seq(input string tag, input logic [7:0] addr, input int n);
    bit a;
    bus_start();
    send_byte(8'hA0, a); chk({tag, " R3 select ack"}, a, 1);
    send_byte(addr, a);  chk({tag, " R3 address ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); chk({tag, " R3 data ack"}, a, 1);
    end
    bus_stop();
  endtask

  task automatic read_random(input string tag, input logic [7:0] addr, input int n);
    bit a;
    bus_start();
    send_byte(8'hA0, a); chk({tag, " R8 select ack"}, a, 1);
    send_byte(addr, a);  chk({tag, " R8 address ack"}, a, 1);
    bus_start();
    send_byte(8'hA1, a); chk({tag, " R8 read select ack"}, a, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic wait_prog();
    repeat (PROG + 20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 data released after reset", sda_pull_low, 0);
    read_random("R1", 8'h11, 2);
    chk("R1 array cleared at 0x11", rbuf[0], 8'h00);
    chk("R1 array cleared at 0x12", rbuf[1], 8'h00);
  endtask

  task automatic t_byte_write();
    wbuf[0] = 8'h5A;
    write_seq("R4", 8'h10, 1);
    wait_prog();
    read_random("R4", 8'h10, 1);
    chk("R4 byte write stored", rbuf[0], 8'h5A);
    read_random("R8", 8'h10, 1);
    chk("R8 random read leaves array unchanged", rbuf[0], 8'h5A);
  endtask

  task automatic t_select();
    bit a;
    bus_start();
    send_byte(8'hB0, a);
    chk("R2 wrong nibble not acknowledged", a, 0);
    send_byte(8'h10, a);
    chk("R2 released until next START", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hAE, a);
    chk("R2 don't-care bits acknowledged", a, 1);
    bus_stop();
  endtask

  task automatic t_we_low();
    bit a;
    we = 1'b0;
    wbuf[0] = 8'h77;
    write_seq("R5", 8'h20, 1);
    bus_start();
    send_byte(8'hA0, a);
    chk("R5 no programming interval without enable", a, 1);
    bus_stop();
    we = 1'b1;
    read_random("R5", 8'h20, 1);
    chk("R5 write blocked by enable low", rbuf[0], 8'h00);
  endtask

  task automatic t_busy();
    bit a;
    wbuf[0] = 8'h66;
    write_seq("R7", 8'h30, 1);
    bus_start();
    send_byte(8'hA0, a);
    chk("R7 select ignored while programming", a, 0);
    bus_stop();
    wait_prog();
    bus_start();
    send_byte(8'hA0, a);
    chk("R7 select acknowledged after interval", a, 1);
    bus_stop();
    read_random("R7", 8'h30, 1);
    chk("R7 data committed", rbuf[0], 8'h66);
  endtask

  task automatic t_page();
    logic [7:0] exp;
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hA0 + 8'(i);
    write_seq("R6", 8'h18, 10);
    wait_prog();
    read_random("R6", 8'h18, 8);
    for (int i = 0; i < 8; i++) begin
      exp = (i < 2) ? (8'hA8 + 8'(i)) : (8'hA0 + 8'(i));
      chk("R6 page wrap content", rbuf[i], exp);
    end
    read_random("R6", 8'h17, 1);
    chk("R6 byte below page untouched", rbuf[0], 8'h00);
    read_random("R6", 8'h20, 1);
    chk("R6 byte above page untouched", rbuf[0], 8'h00);
  endtask

  task automatic t_wrap();
    bit a;
    logic [7:0] d;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    write_seq("R9", 8'h7E, 2);
    wait_prog();
    wbuf[0] = 8'h3C; wbuf[1] = 8'h4D;
    write_seq("R9", 8'h00, 2);
    wait_prog();
    read_random("R9", 8'h7E, 3);
    chk("R9 sequential byte 0x7E", rbuf[0], 8'h11);
    chk("R9 sequential byte 0x7F", rbuf[1], 8'h22);
    chk("R9 sequential wraps to 0x00", rbuf[2], 8'h3C);
    bus_start();
    send_byte(8'hA1, a);
    chk("R10 current read select ack", a, 1);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R10 current address read", d, 8'h4D);
  endtask

  task automatic t_nack();
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA0, a);
    send_byte(8'h10, a);
    bus_start();
    send_byte(8'hA1, a);
    recv_byte(1'b0, d);
    chk("R11 byte before NACK", d, 8'h5A);
    recv_byte(1'b0, d);
    chk("R11 line released after NACK", d, 8'hFF);
    chk("R11 pull-low idle after NACK", sda_pull_low, 0);
    bus_stop();
  endtask

  task automatic t_msb();
    wbuf[0] = 8'h9E;
    write_seq("R12", 8'h85, 1);
    wait_prog();
    read_random("R12", 8'h05, 1);
    chk("R12 address bit 7 ignored", rbuf[0], 8'h9E);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_byte_write();
    t_select();
    t_we_low();
    t_busy();
    t_page();
    t_wrap();
    t_nack();
    t_msb();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1-to-end run hung actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule